// File: doc/BRIEF.md
# Windowed Service Watchdog

This block is a watchdog counter that asks the system to reset when software stops servicing it. Software picks a timeout code (two bits) and a count source: either a slow low-power tick of about 1 kHz, given to the block as a clock-enable strobe, or the bus clock itself. Each source has its own set of three timeout lengths. Timeout code 00 turns the watchdog off. The code and the source can be written once after reset. The first write sticks and every later write is dropped.

Software services the watchdog by writing the key 0x55 and then the key 0xAA. A completed service restarts the count. Window mode can be turned on while the bus clock is the source. In that mode a service is legal only in the last quarter of the period, and a service that comes too early is treated as a fault. A timeout or an early service raises a reset request for one cycle and sets a sticky cause flag. The reset controller that acts on the request is a separate block.

Top module: `wdog_top`

## Requirements
- R1: Timeout code 00 disables the watchdog on either source. The counter stays at zero, no reset request is raised, and a service (early or not) has no effect.
- R2: With the tick source (`cfgBusClk`=0), codes 01, 10 and 11 give periods of 2^TICK_SH1, 2^TICK_SH2 and 2^TICK_SH3 ticks. The defaults are 2^5, 2^8 and 2^10.
- R3: With the bus-clock source (`cfgBusClk`=1), codes 01, 10 and 11 give periods of 2^BUS_SH1, 2^BUS_SH2 and 2^BUS_SH3 cycles. The defaults are 2^13, 2^16 and 2^18.
- R4: If an advancing cycle finds the count at period-1, `rstReq` is high for the following cycle and the count restarts from zero. From a restart, the next overflow comes after exactly one period of advances.
- R5: `wdCause` is low after reset. Any reset request sets it, and it stays set until the next reset.
- R6: A service is one `svcWr` with `svcData`=0x55 followed later by one `svcWr` with 0xAA. Another write with a different value in between cancels the 0x55. A 0xAA that does not follow a 0x55 does nothing. A completed service restarts the count.
- R7: With `winEn`=1 and the bus source, a service is accepted only when the count is at least 3/4 of the period (6144, 49152 and 196608 by default). A service completed below that point raises the same reset request as a timeout.
- R8: With the tick source, `winEn` has no effect. A service is accepted at any count.
- R9: The first `cfgWr` after reset loads the code and the source, even when they equal the reset values. Every later `cfgWr` is ignored.
- R10: After reset the code is 11 and the source is the tick, so the watchdog is running.
- R11: With the tick source the count advances only in cycles where `tickEn` is high. With the bus source it advances every cycle.
- R12: The first (accepted) configuration write restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle strobe from the slow low-power tick |
| cfgWr | input | 1 | Configuration write strobe |
| cfgTimeout | input | 2 | Timeout code written by `cfgWr` |
| cfgBusClk | input | 1 | Source written by `cfgWr`: 1 bus clock, 0 tick |
| svcWr | input | 1 | Service register write strobe |
| svcData | input | 8 | Service register write data |
| winEn | input | 1 | Window mode enable |
| rstReq | output | 1 | Reset request, one cycle per fault |
| wdCause | output | 1 | Sticky flag: a watchdog reset was requested |

## Verification
Some properties are checked on every cycle by the assertions:
- The configuration cannot change once locked.
- The count moves by exactly one or holds according to the control strobes.
- The count never passes the period limit.
- A request always comes with a cleared count.
- The cause flag never falls.

Other behaviour shows up only in the bench scenarios, where a cycle-exact reference model is compared on every clock:
- The actual period lengths for each code and source.
- The exact cycle at which the window opens.
- Key ordering.
- The write-once behaviour of a configuration that equals the reset value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic adv;   // count one step
    logic clr;   // restart count (service or config)
    logic fire;  // raise reset request and restart
  } wdStrobe_t;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int TICK_SH1 = 5,
  parameter int TICK_SH2 = 8,
  parameter int TICK_SH3 = 10,
  parameter int BUS_SH1  = 13,
  parameter int BUS_SH2  = 16,
  parameter int BUS_SH3  = 18,
  parameter int CNT_W    = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cfgWr,
  input  logic [1:0]       cfgTimeout,
  input  logic             cfgBusClk,
  input  logic             svcWr,
  input  logic [7:0]       svcData,
  input  logic             winEn,
  input  logic             atLast,
  input  logic             belowWin,
  output logic [CNT_W-1:0] lastCnt,
  output logic [CNT_W-1:0] winCnt,
  output wdStrobe_t        strb
);

  logic [1:0] code;
  logic       srcBus;
  logic       locked;
  logic       armed;
  logic [4:0] shSel;
  logic [CNT_W:0] fullVal;
  logic [CNT_W:0] lastWide;
  logic [CNT_W:0] winWide;
  logic enabled, cfgTake, svcDone, svcEarly, svcOk;

  // Period exponent per source and code
  always_comb begin
    unique case ({srcBus, code})
      3'b0_01: shSel = 5'(TICK_SH1);
      3'b0_10: shSel = 5'(TICK_SH2);
      3'b0_11: shSel = 5'(TICK_SH3);
      3'b1_01: shSel = 5'(BUS_SH1);
      3'b1_10: shSel = 5'(BUS_SH2);
      3'b1_11: shSel = 5'(BUS_SH3);
      default: shSel = 5'd0;
    endcase
  end

  assign fullVal  = (CNT_W+1)'(1) << shSel;
  assign lastWide = fullVal - (CNT_W+1)'(1);
  assign winWide  = fullVal - (fullVal >> 2);
  assign lastCnt  = lastWide[CNT_W-1:0];
  assign winCnt   = winWide[CNT_W-1:0];

  assign enabled  = (code != 2'b00);
  assign cfgTake  = cfgWr && !locked;
  assign svcDone  = svcWr && (svcData == KEY_FIRE) && armed;
  assign svcEarly = svcDone && enabled && winEn && srcBus && belowWin;
  assign svcOk    = svcDone && enabled && !svcEarly;

  always_comb begin
    strb.adv  = enabled && (srcBus || tickEn);
    strb.fire = svcEarly || (strb.adv && atLast && !svcOk);
    strb.clr  = svcOk || cfgTake;
  end

  // Write-once configuration and key sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code   <= 2'b11;
      srcBus <= 1'b0;
      locked <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (cfgTake) begin
        code   <= cfgTimeout;
        srcBus <= cfgBusClk;
        locked <= 1'b1;
      end
      if (svcWr) armed <= (svcData == KEY_ARM);
    end
  end

  // R9: once locked, configuration never moves
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked)) |-> ($stable(code) && $stable(srcBus)));

  // R9: an accepted write locks the configuration
  p_cfg_locks_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> locked);

endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strb,
  input  logic [CNT_W-1:0] lastCnt,
  input  logic [CNT_W-1:0] winCnt,
  output logic             atLast,
  output logic             belowWin,
  output logic             rstReq,
  output logic             wdCause
);

  logic [CNT_W-1:0] cnt;

  assign atLast   = (cnt == lastCnt);
  assign belowWin = (cnt < winCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      rstReq  <= 1'b0;
      wdCause <= 1'b0;
    end else begin
      rstReq <= strb.fire;
      if (strb.fire) wdCause <= 1'b1;
      if (strb.fire || strb.clr) cnt <= '0;
      else if (strb.adv)         cnt <= cnt + 1'b1;
    end
  end

  // R4: a request always comes with a restarted count
  p_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (cnt == '0));

  // R4: count never passes the period limit
  p_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCnt);

  // R5: cause flag is sticky
  p_cause_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    wdCause |=> wdCause);

  // R11: an advance steps by one
  p_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && !strb.clr && !strb.fire) |=> (cnt == $past(cnt) + 1'b1));

  // R11: without advance the count holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.adv && !strb.clr && !strb.fire) |=> $stable(cnt));

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int TICK_SH1 = 5,
  parameter int TICK_SH2 = 8,
  parameter int TICK_SH3 = 10,
  parameter int BUS_SH1  = 13,
  parameter int BUS_SH2  = 16,
  parameter int BUS_SH3  = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       cfgWr,
  input  logic [1:0] cfgTimeout,
  input  logic       cfgBusClk,
  input  logic       svcWr,
  input  logic [7:0] svcData,
  input  logic       winEn,
  output logic       rstReq,
  output logic       wdCause
);

  localparam int CNT_W = (BUS_SH3 > TICK_SH3) ? BUS_SH3 : TICK_SH3;

  wdStrobe_t        strb;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] winCnt;
  logic             atLast;
  logic             belowWin;

  wdog_ctrl #(
    .TICK_SH1(TICK_SH1), .TICK_SH2(TICK_SH2), .TICK_SH3(TICK_SH3),
    .BUS_SH1(BUS_SH1),   .BUS_SH2(BUS_SH2),   .BUS_SH3(BUS_SH3),
    .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .cfgWr(cfgWr), .cfgTimeout(cfgTimeout), .cfgBusClk(cfgBusClk),
    .svcWr(svcWr), .svcData(svcData), .winEn(winEn),
    .atLast(atLast), .belowWin(belowWin),
    .lastCnt(lastCnt), .winCnt(winCnt), .strb(strb)
  );

  wdog_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lastCnt(lastCnt), .winCnt(winCnt),
    .atLast(atLast), .belowWin(belowWin),
    .rstReq(rstReq), .wdCause(wdCause)
  );

endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
  localparam int T1 = 3, T2 = 4, T3 = 5;
  localparam int B1 = 6, B2 = 7, B3 = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic cfgWr = 1'b0;
  logic [1:0] cfgTimeout = 2'b00;
  logic cfgBusClk = 1'b0;
  logic svcWr = 1'b0;
  logic [7:0] svcData = 8'h00;
  logic winEn = 1'b0;
  logic rstReq, wdCause;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wdog_top #(.TICK_SH1(T1), .TICK_SH2(T2), .TICK_SH3(T3),
             .BUS_SH1(B1), .BUS_SH2(B2), .BUS_SH3(B3)) i_wdog_top (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgWr(cfgWr),
    .cfgTimeout(cfgTimeout), .cfgBusClk(cfgBusClk), .svcWr(svcWr),
    .svcData(svcData), .winEn(winEn), .rstReq(rstReq), .wdCause(wdCause)
  );

  // Tick strobe: high one cycle in three
  int tickPh = 0;
  always @(negedge clk) begin
    tickPh = (tickPh == 2) ? 0 : tickPh + 1;
    tickEn = (tickPh == 0);
  end

  function automatic int periodOf(int c, bit bus);
    int sh;
    if (c == 0) return 0;
    if (bus) sh = (c == 1) ? B1 : (c == 2) ? B2 : B3;
    else     sh = (c == 1) ? T1 : (c == 2) ? T2 : T3;
    return 1 << sh;
  endfunction

  // Behavioural reference model
  int mCode, mCnt;
  bit mBus, mLock, mArmed, mReq, mCause;
  always @(posedge clk or negedge rstN) begin
    int n, w;
    bit en, done, early, ok, adv, fire, take;
    if (!rstN) begin
      mCode = 3; mBus = 0; mLock = 0; mArmed = 0; mCnt = 0; mReq = 0; mCause = 0;
    end else begin
      n = periodOf(mCode, mBus);
      w = n - n / 4;
      en = (mCode != 0);
      done = svcWr && (svcData == 8'hAA) && mArmed;
      early = done && en && winEn && mBus && (mCnt < w);
      ok = done && en && !early;
      adv = en && (mBus || tickEn);
      fire = early || (adv && (mCnt == n - 1) && !ok);
      take = cfgWr && !mLock;
      mReq = fire;
      if (fire) mCause = 1;
      if (fire || ok || take) mCnt = 0;
      else if (adv) mCnt = mCnt + 1;
      if (svcWr) mArmed = (svcData == 8'h55);
      if (take) begin mCode = int'(cfgTimeout); mBus = cfgBusClk; mLock = 1; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 rstReq vs model", int'(rstReq), int'(mReq));
      chk("R5 wdCause vs model", int'(wdCause), int'(mCause));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cfgWr = 1'b0; svcWr = 1'b0; winEn = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic cfg(int c, bit bus);
    cfgWr = 1'b1; cfgTimeout = 2'(c); cfgBusClk = bus;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic svc(logic [7:0] d);
    svcWr = 1'b1; svcData = d;
    @(negedge clk);
    svcWr = 1'b0;
  endtask

  task automatic waitReq(int limit, output int cyc);
    cyc = 0;
    while (!rstReq && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic countReq(int n, output int pulses);
    pulses = 0;
    repeat (n) begin
      @(negedge clk);
      if (rstReq) pulses++;
    end
  endtask

  initial begin
    int cyc, p, n, w;
    idle(1);
    doReset();
    // R10 / R5: reset state
    chk("R5 cause low after reset", int'(wdCause), 0);
    chk("R10 no request after reset", int'(rstReq), 0);
    // R10: default runs tick source code 11
    waitReq(1000, cyc);
    chk("R10 default period in range", int'(cyc >= 3*(1<<T3)-5 && cyc <= 3*(1<<T3)+3), 1);
    idle(5);
    chk("R5 cause stays set", int'(wdCause), 1);

    // R3 / R4: exact overflow on bus source, each code
    for (int c = 1; c <= 3; c++) begin
      n = periodOf(c, 1);
      doReset();
      cfg(c, 1);
      idle(n - 1); chk("R3 no request before overflow", int'(rstReq), 0);
      idle(1);     chk("R3 request at overflow", int'(rstReq), 1);
      idle(1);     chk("R4 request lasts one cycle", int'(rstReq), 0);
      idle(n - 2); chk("R4 restarted count no early request", int'(rstReq), 0);
      idle(1);     chk("R4 second overflow one period later", int'(rstReq), 1);
    end

    // R2 / R11: tick source, each code
    for (int c = 1; c <= 3; c++) begin
      n = periodOf(c, 0);
      doReset();
      cfg(c, 0);
      waitReq(4 * n + 20, cyc);
      chk("R2 R11 tick period in range", int'(cyc >= 3*n-3 && cyc <= 3*n+3), 1);
    end

    // R7: window opening edge on bus source, each code
    for (int c = 1; c <= 3; c++) begin
      n = periodOf(c, 1);
      w = n - n / 4;
      doReset(); winEn = 1'b1;
      cfg(c, 1);
      idle(w - 2); svc(8'h55); svc(8'hAA);
      chk("R7 service one count before window faults", int'(rstReq), 1);
      doReset(); winEn = 1'b1;
      cfg(c, 1);
      idle(w - 1); svc(8'h55); svc(8'hAA);
      chk("R7 service at window opening accepted", int'(rstReq), 0);
      idle(n - 1); chk("R6 service restarts count", int'(rstReq), 0);
      idle(1);     chk("R6 overflow one period after service", int'(rstReq), 1);
    end

    // R6: bad order and disarming leave count alone
    n = periodOf(1, 1);
    doReset();
    cfg(1, 1);
    idle(10); svc(8'hAA); svc(8'h55); svc(8'h33); svc(8'hAA);
    idle(n - 15); chk("R6 bad sequence no early request", int'(rstReq), 0);
    idle(1);      chk("R6 bad sequence leaves overflow time", int'(rstReq), 1);

    // R8: window ignored on tick source
    doReset(); winEn = 1'b1;
    cfg(1, 0);
    idle(3); svc(8'h55); svc(8'hAA);
    chk("R8 early service on tick source accepted", int'(rstReq), 0);
    chk("R8 no cause on tick source service", int'(wdCause), 0);

    // R1: disabled code on both sources
    doReset(); winEn = 1'b1;
    cfg(0, 1);
    svc(8'h55); svc(8'hAA);
    countReq(600, p);
    chk("R1 bus source disabled no requests", p, 0);
    doReset();
    cfg(0, 0);
    countReq(400, p);
    chk("R1 tick source disabled no requests", p, 0);
    chk("R1 disabled cause stays low", int'(wdCause), 0);

    // R9: first write equal to reset value still locks
    doReset();
    cfg(3, 0);
    cfg(1, 1);
    waitReq(1000, cyc);
    chk("R9 later write ignored after matching first write",
        int'(cyc >= 3*(1<<T3)-5 && cyc <= 3*(1<<T3)+3), 1);
    // R9 / R12: second write neither changes nor restarts
    n = periodOf(1, 1);
    doReset();
    cfg(1, 1);
    idle(10); cfg(3, 0);
    idle(n - 12); chk("R9 second write ignored, no early request", int'(rstReq), 0);
    idle(1);      chk("R9 second write ignored, overflow on time", int'(rstReq), 1);

    // R12: first write restarts count
    doReset();
    idle(20);
    cfg(1, 1);
    idle(n - 1); chk("R12 config write restarts count", int'(rstReq), 0);
    idle(1);     chk("R12 overflow one period after config", int'(rstReq), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule